// File: doc/BRIEF.md
# Dual-Owner Bus-Mapped I/O Port

This block is a bidirectional I/O port whose pins can be owned, one bit at a time, by either of two masters. The first is a microcontroller. It sees four registers through a small synchronous read/write interface. Through these registers it sets each pin's owner and direction, supplies the output data, and samples the pins. The second master is an on-chip programmable logic array. The array provides its own output data vector and a per-pin output-enable term, and it always receives the raw pin values.

The pins are modelled as three separate vectors: output value, output enable and input value. A pin's output enable is the OR of the direction register bit and the logic array's enable term for that pin. The owner bit of the pin selects where the driven value comes from.

A build parameter removes the owner register. In that variant each pin's owner is fixed when the port is built. The default fixed setting gives every pin to the microcontroller.

Top module: `mcu_pld_ioport`

## Requirements
- R1: After reset the data-out, direction and owner registers read 0. With the logic array's enables low, `pin_oe` is 0 and `pin_out` is 0.
- R2: The register offsets are 1 = data-out, 2 = direction and 3 = owner. A write with `reg_wr` high is captured on a rising clock edge. It is visible on the next read and on the pins after that edge, not before it. Each of these three registers reads back its stored value.
- R3: A direction bit of 1 means output. `pin_oe[i]` equals `dir[i] | pla_oe[i]` in every mode.
- R4: A pin whose owner bit is 0 (microcontroller) drives `pin_out[i]` from data-out bit i.
- R5: A pin whose owner bit is 1 (logic array) drives `pin_out[i]` from `pla_out[i]`. Each bit is selected independently of the other bits.
- R6: A read at offset 0 returns `pin_in` through a two-stage synchronizer. A change that is set up before rising edge k becomes visible after edge k+1. After edge k alone, the read still shows the old value.
- R7: Offset 0 is read-only. A write to it changes none of the registers and none of the pin outputs.
- R8: `pla_in` always equals `pin_in`, whatever the owner and direction settings.
- R9: When built with `HAS_OWNER_REG = 0`, offset 3 reads the build-time mask `FIXED_PLA_MASK`. Writes to offset 3 are then ignored, and the mask alone selects each pin's owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Read data, a combinational function of `reg_addr` |
| pin_in | input | WIDTH | Sampled pin levels |
| pin_out | output | WIDTH | Value driven onto the pins |
| pin_oe | output | WIDTH | Per-pin output enable |
| pla_out | input | WIDTH | Output data from the logic array |
| pla_oe | input | WIDTH | Per-pin output-enable term from the logic array |
| pla_in | output | WIDTH | Pin levels passed to the logic array |

## Verification
The hardest case to reach is a port where microcontroller-owned and array-owned pins coexist. In that case the direction bits and the array's enable terms disagree pin by pin, so a wrong select or a wrong OR shows up on only some bits. The stimulus writes an owner mask that splits the port. It then applies direction and enable patterns whose overlap leaves some pins enabled only by the array and others only by the register, and checks each bit of the composed output. The synchronizer latency is checked by reading offset 0 after one edge and again after two edges, counted from a pin change made between edges.

// File: rtl/ioport_pkg.sv
package ioport_pkg;

  localparam int unsigned OFS_W = 2;

  typedef enum logic [OFS_W-1:0] {
    OFS_PINS  = 2'd0,
    OFS_DOUT  = 2'd1,
    OFS_DIR   = 2'd2,
    OFS_OWNER = 2'd3
  } ioport_ofs_e;

  // value placed on one pin: owner 1 selects the logic array
  function automatic logic pick_drive(input logic owner_pla,
                                      input logic pla_val,
                                      input logic mcu_val);
    return owner_pla ? pla_val : mcu_val;
  endfunction

  // enable of one pin: register direction or array term
  function automatic logic merge_oe(input logic dir_bit,
                                    input logic pla_term);
    return dir_bit | pla_term;
  endfunction

endpackage

// File: rtl/ioport_sync.sv
module ioport_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/ioport_regs.sv
module ioport_regs
  import ioport_pkg::*;
#(
  parameter int unsigned     WIDTH          = 8,
  parameter bit              HAS_OWNER_REG  = 1'b1,
  parameter logic [WIDTH-1:0] FIXED_PLA_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] pins_sync,
  output logic [WIDTH-1:0] rdata,
  output logic [WIDTH-1:0] dout_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] owner_q,
  output logic             wr_dout_evt,
  output logic             wr_dir_evt,
  output logic             wr_owner_evt
);

  ioport_ofs_e ofs;
  assign ofs = ioport_ofs_e'(addr);

  assign wr_dout_evt  = wr_en && (ofs == OFS_DOUT);
  assign wr_dir_evt   = wr_en && (ofs == OFS_DIR);
  assign wr_owner_evt = wr_en && (ofs == OFS_OWNER) && HAS_OWNER_REG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           dout_q <= '0;
    else if (wr_dout_evt) dout_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dir_q <= '0;
    else if (wr_dir_evt) dir_q <= wdata;
  end

  if (HAS_OWNER_REG) begin : g_owner_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            owner_q <= '0;
      else if (wr_owner_evt) owner_q <= wdata;
    end
  end else begin : g_owner_fixed
    assign owner_q = FIXED_PLA_MASK;
  end

  always_comb begin
    unique case (ofs)
      OFS_PINS:  rdata = pins_sync;
      OFS_DOUT:  rdata = dout_q;
      OFS_DIR:   rdata = dir_q;
      OFS_OWNER: rdata = owner_q;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/ioport_pinmux.sv
module ioport_pinmux
  import ioport_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] owner,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] dout,
  input  logic [WIDTH-1:0] pla_out,
  input  logic [WIDTH-1:0] pla_oe,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign pin_out[i] = pick_drive(owner[i], pla_out[i], dout[i]);
    assign pin_oe[i]  = merge_oe(dir[i], pla_oe[i]);
  end

endmodule

// File: rtl/mcu_pld_ioport.sv
module mcu_pld_ioport
  import ioport_pkg::*;
#(
  parameter int unsigned      WIDTH          = 8,
  parameter int unsigned      SYNC_STAGES    = 2,
  parameter bit               HAS_OWNER_REG  = 1'b1,
  parameter logic [WIDTH-1:0] FIXED_PLA_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  input  logic [WIDTH-1:0] pla_out,
  input  logic [WIDTH-1:0] pla_oe,
  output logic [WIDTH-1:0] pla_in
);

  // internal events and state, named for the checker
  logic [WIDTH-1:0] pins_sync;
  logic [WIDTH-1:0] dout_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] owner_q;
  logic             wr_dout_evt;
  logic             wr_dir_evt;
  logic             wr_owner_evt;

  ioport_sync #(
    .WIDTH  (WIDTH),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pins_sync)
  );

  ioport_regs #(
    .WIDTH          (WIDTH),
    .HAS_OWNER_REG  (HAS_OWNER_REG),
    .FIXED_PLA_MASK (FIXED_PLA_MASK)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (reg_wr),
    .addr         (reg_addr),
    .wdata        (reg_wdata),
    .pins_sync    (pins_sync),
    .rdata        (reg_rdata),
    .dout_q       (dout_q),
    .dir_q        (dir_q),
    .owner_q      (owner_q),
    .wr_dout_evt  (wr_dout_evt),
    .wr_dir_evt   (wr_dir_evt),
    .wr_owner_evt (wr_owner_evt)
  );

  ioport_pinmux #(
    .WIDTH (WIDTH)
  ) u_pinmux (
    .owner   (owner_q),
    .dir     (dir_q),
    .dout    (dout_q),
    .pla_out (pla_out),
    .pla_oe  (pla_oe),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  // the array always sees the raw pin levels
  assign pla_in = pin_in;

endmodule

// File: rtl/ioport_chk.sv
module ioport_chk #(
  parameter int unsigned      WIDTH          = 8,
  parameter bit               HAS_OWNER_REG  = 1'b1,
  parameter logic [WIDTH-1:0] FIXED_PLA_MASK = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [WIDTH-1:0] reg_wdata,
  input logic [WIDTH-1:0] reg_rdata,
  input logic [WIDTH-1:0] pin_in,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] pla_out,
  input logic [WIDTH-1:0] pla_oe,
  input logic [WIDTH-1:0] pla_in,
  input logic [WIDTH-1:0] dout_q,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] owner_q
);

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  a_r2_dout_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> (dout_q == $past(reg_wdata)));

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=> (dir_q == $past(reg_wdata)));

  a_r3_oe_merge: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe == (dir_q | pla_oe));

  a_r4_mcu_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~owner_q) == (dout_q & ~owner_q));

  a_r5_pla_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & owner_q) == (pla_out & owner_q));

  a_r6_pin_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && reg_addr == 2'd0) |-> (reg_rdata == $past(pin_in, 2)));

  a_r7_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=>
      ($stable(dout_q) && $stable(dir_q) && $stable(owner_q)));

  a_r8_pla_in: assert property (@(posedge clk) disable iff (!rst_n)
    pla_in == pin_in);

  if (!HAS_OWNER_REG) begin : g_fixed
    a_r9_owner_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      owner_q == FIXED_PLA_MASK);
  end

endmodule

bind mcu_pld_ioport ioport_chk #(
  .WIDTH          (WIDTH),
  .HAS_OWNER_REG  (HAS_OWNER_REG),
  .FIXED_PLA_MASK (FIXED_PLA_MASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pla_out   (pla_out),
  .pla_oe    (pla_oe),
  .pla_in    (pla_in),
  .dout_q    (dout_q),
  .dir_q     (dir_q),
  .owner_q   (owner_q)
);

// File: tb/mcu_pld_ioport_tb.sv
module mcu_pld_ioport_tb;

  localparam int W = 8;
  localparam logic [W-1:0] FIX_MASK = 8'hF0;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pla_out = '0;
  logic [W-1:0] pla_oe = '0;
  logic [W-1:0] reg_rdata, pin_out, pin_oe, pla_in;
  logic [W-1:0] f_rdata, f_out, f_oe, f_pla_in;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  mcu_pld_ioport #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pla_out(pla_out),
    .pla_oe(pla_oe), .pla_in(pla_in)
  );

  mcu_pld_ioport #(.WIDTH(W), .HAS_OWNER_REG(1'b0), .FIXED_PLA_MASK(FIX_MASK)) u_dut_fixed (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(f_rdata), .pin_in(pin_in),
    .pin_out(f_out), .pin_oe(f_oe), .pla_out(pla_out),
    .pla_oe(pla_oe), .pla_in(f_pla_in)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d, output logic [W-1:0] fd);
    reg_addr = a;
    #1;
    d = reg_rdata;
    fd = f_rdata;
  endtask

  task automatic t_reset;
    logic [W-1:0] d, fd;
    rd(2'd1, d, fd); check("R1 dout reset", d, 8'h00);
    rd(2'd2, d, fd); check("R1 dir reset", d, 8'h00);
    rd(2'd3, d, fd); check("R1 owner reset", d, 8'h00);
    check("R1 oe reset", pin_oe, 8'h00);
    check("R1 out reset", pin_out, 8'h00);
  endtask

  task automatic t_regs;
    logic [W-1:0] d, fd;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'hA5;
    #1;
    check("R2 dout not before edge", reg_rdata, 8'h00);
    @(negedge clk);
    reg_wr = 1'b0;
    rd(2'd1, d, fd); check("R2 dout readback", d, 8'hA5);
    wr(2'd2, 8'h3C);
    rd(2'd2, d, fd); check("R2 dir readback", d, 8'h3C);
    wr(2'd3, 8'h0F);
    rd(2'd3, d, fd); check("R2 owner readback", d, 8'h0F);
  endtask

  task automatic t_oe;
    pla_oe = 8'hC1;
    #1;
    check("R3 oe merge", pin_oe, 8'hFD);
    pla_oe = 8'h00;
    #1;
    check("R3 oe dir only", pin_oe, 8'h3C);
  endtask

  task automatic t_drive;
    pla_out = 8'h96;
    #1;
    check("R4 R5 split owners", pin_out, 8'hA6);
    wr(2'd3, 8'h00);
    check("R4 all mcu", pin_out, 8'hA5);
    wr(2'd3, 8'hFF);
    check("R5 all array", pin_out, 8'h96);
    wr(2'd3, 8'h0F);
  endtask

  task automatic t_sync;
    logic [W-1:0] d, fd;
    @(negedge clk);
    pin_in = 8'h5A;
    rd(2'd0, d, fd); check("R6 no change yet", d, 8'h00);
    @(negedge clk);
    rd(2'd0, d, fd); check("R6 one edge", d, 8'h00);
    @(negedge clk);
    rd(2'd0, d, fd); check("R6 two edges", d, 8'h5A);
  endtask

  task automatic t_ro;
    logic [W-1:0] d, fd;
    wr(2'd0, 8'h77);
    rd(2'd1, d, fd); check("R7 dout kept", d, 8'hA5);
    rd(2'd2, d, fd); check("R7 dir kept", d, 8'h3C);
    rd(2'd3, d, fd); check("R7 owner kept", d, 8'h0F);
    check("R7 pins kept", pin_out, 8'hA6);
  endtask

  task automatic t_pla_in;
    pin_in = 8'hC3;
    #1;
    check("R8 pla_in follows", pla_in, 8'hC3);
    pin_in = 8'h3C;
    #1;
    check("R8 pla_in follows again", pla_in, 8'h3C);
  endtask

  task automatic t_fixed;
    logic [W-1:0] d, fd;
    rd(2'd3, d, fd); check("R9 mask read", fd, FIX_MASK);
    wr(2'd3, 8'h00);
    rd(2'd3, d, fd); check("R9 write ignored", fd, FIX_MASK);
    check("R9 mask selects owner", f_out, (pla_out & FIX_MASK) | (8'hA5 & ~FIX_MASK));
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    t_oe();
    t_drive();
    t_sync();
    t_ro();
    t_pla_in();
    t_fixed();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule